// File: doc/BRIEF.md
# Three-Stage Sharpened Comb Decimator

This block lowers the sample rate of a signed fixed-point stream by 16 without any multiplier. Three decimating stages share the work. The first stage is a cascade of plain moving sums of length M1 and keeps one result in M1. The second and third stages are sharpened comb decimators of length M2 and M3. A sharpened stage builds a basic filter P from K cascaded moving sums. It then forms the combination 3·P²·z^-D − 2·P³, which flattens the passband and deepens the stopband. Each stage runs only on the samples that the stage before it has kept.

Every moving sum is written in non-recursive form, as a direct sum of M taps. All stages work on unscaled integer sums in one wide internal word, so the chain loses no precision. A single arithmetic shift at the output removes the accumulated power-of-two gain. The result is then rounded and saturated to the output width. The input side has a valid strobe. On each 16th accepted sample the output produces one registered, valid-flagged sample.

Top module: `sharp_comb_decim`

## Requirements
- R1: `out_valid` is a one-cycle pulse issued exactly once per 16 accepted inputs, counted from reset. It is high in the fourth cycle after the cycle in which the 16th, 32nd, ... accepted input is presented, and low in every other cycle.
- R2: A cycle with `in_valid` low changes nothing. The value on `in_data` is ignored, no delay line shifts and no decimation phase advances.
- R3: Stage one applies L cascaded length-M1 moving sums to the accepted samples. It passes on the sum formed at the last (M1-th) sample of each group of M1.
- R4: Stages two and three each take the samples kept by the previous stage as input. From that input x they form P = K cascaded length-M moving sums and the output 3·M^K·P²x[n−D] − 2·P³x[n], where D = K·(M−1)/2. They keep the last of each group of M, with M = M2 for stage two and M = M3 for stage three.
- R5: A constant input c held long enough to fill every stage yields `out_data` equal to c exactly (unity DC gain).
- R6: The final wide value v is scaled by 2^-SH, where SH = L·log2(M1) + 3·K·(log2(M2) + log2(M3)) (22 by default). It is rounded half toward plus infinity: floor((v + 2^(SH−1)) / 2^SH).
- R7: A scaled result outside the signed W_OUT range is clamped to the most positive or most negative W_OUT value.
- R8: While `rst` is high, all delay lines and phase counters clear, and `out_valid` and `out_data` are 0. After reset the 16-input phase starts again from the first accepted sample.
- R9: `out_data` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W_IN | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | W_OUT | Signed decimated, rounded and saturated sample |

## Verification
With a gapless input stream, one clock edge can accept a new sample, make stage one capture a kept sum, and shift the stage-two sharpening delay line. The same edge can also move an earlier result through stage three and the output register. The bench provokes this with long runs of back-to-back inputs, and provokes the opposite case with random strobe gaps that carry junk data. A bench model of the three stages, with its own index arithmetic, judges every output value. A cycle-stamped queue judges every output pulse against the fourth-cycle rule.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic {
    STG_PLAIN = 1'b0,
    STG_SHARP = 1'b1
  } stg_kind_e;

  // Group delay, in stage samples, of K cascaded length-M sums.
  function automatic int sharp_delay(input int m, input int k);
    return (k * (m - 1)) / 2;
  endfunction

  // log2 of the gain of K cascaded length-M sums (M is a power of two).
  function automatic int gain_log2(input int m, input int k);
    return k * $clog2(m);
  endfunction

endpackage

// File: rtl/sdec_boxsum.sv
module sdec_boxsum #(
  parameter int W = 44,
  parameter int M = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  logic signed [W-1:0] tap [M-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < M - 1; i++) tap[i] <= '0;
    end else if (en) begin
      tap[0] <= din;
      for (int i = 1; i < M - 1; i++) tap[i] <= tap[i-1];
    end
  end

  always_comb begin
    dout = din;
    for (int i = 0; i < M - 1; i++) dout = dout + tap[i];
  end

endmodule

// File: rtl/sdec_stage.sv
module sdec_stage
  import sdec_pkg::*;
#(
  parameter int        W    = 44,
  parameter int        M    = 2,
  parameter int        NSEC = 2,
  parameter stg_kind_e KIND = STG_PLAIN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic                dvld,
  output logic signed [W-1:0] dout
);

  localparam int NCH = (KIND == STG_SHARP) ? 3 * NSEC : NSEC;
  localparam int PW  = (M > 1) ? $clog2(M) : 1;

  logic signed [W-1:0] chain [NCH+1];
  logic signed [W-1:0] y;
  logic [PW-1:0]       ph;

  assign chain[0] = din;

  for (genvar g = 0; g < NCH; g++) begin : g_sec
    sdec_boxsum #(.W(W), .M(M)) u_sec (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .din (chain[g]),
      .dout(chain[g+1])
    );
  end

  if (KIND == STG_SHARP) begin : g_sharp
    localparam int D  = sharp_delay(M, NSEC);
    localparam int GS = gain_log2(M, NSEC);
    logic signed [W-1:0] dl [D];
    logic signed [W-1:0] aligned;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < D; i++) dl[i] <= '0;
      end else if (en) begin
        dl[0] <= chain[2*NSEC];
        for (int i = 1; i < D; i++) dl[i] <= dl[i-1];
      end
    end

    assign aligned = dl[D-1] <<< GS;
    assign y = (aligned <<< 1) + aligned - (chain[NCH] <<< 1);
  end else begin : g_plain
    assign y = chain[NCH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      dvld <= 1'b0;
      dout <= '0;
    end else begin
      dvld <= en && (ph == PW'(M - 1));
      if (en) begin
        ph <= (ph == PW'(M - 1)) ? '0 : ph + 1'b1;
        if (ph == PW'(M - 1)) dout <= y;
      end
    end
  end

endmodule

// File: rtl/sdec_round_sat.sv
module sdec_round_sat #(
  parameter int W  = 44,
  parameter int SH = 22,
  parameter int WO = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [W-1:0]  din,
  output logic                 dvld,
  output logic signed [WO-1:0] dout
);

  localparam logic signed [W-1:0] HALF = {{(W-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  localparam logic signed [W-1:0] HI   = {{(W-WO+1){1'b0}}, {(WO-1){1'b1}}};
  localparam logic signed [W-1:0] LO   = {{(W-WO+1){1'b1}}, {(WO-1){1'b0}}};

  logic signed [W-1:0] q;

  assign q = (din + HALF) >>> SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      dvld <= 1'b0;
      dout <= '0;
    end else begin
      dvld <= en;
      if (en) begin
        if (q > HI)      dout <= HI[WO-1:0];
        else if (q < LO) dout <= LO[WO-1:0];
        else             dout <= q[WO-1:0];
      end
    end
  end

endmodule

// File: rtl/sharp_comb_decim.sv
module sharp_comb_decim
  import sdec_pkg::*;
#(
  parameter int W_IN  = 16,
  parameter int W_OUT = 16,
  parameter int M1    = 2,
  parameter int M2    = 2,
  parameter int M3    = 4,
  parameter int L     = 4,
  parameter int K     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [W_IN-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [W_OUT-1:0] out_data
);

  localparam int SH    = gain_log2(M1, L) + 3 * gain_log2(M2, K) + 3 * gain_log2(M3, K);
  localparam int ACC_W = W_IN + SH + 6;

  logic signed [ACC_W-1:0] x_ext, s1_d, s2_d, s3_d;
  logic                    s1_vld, s2_vld, s3_vld;

  assign x_ext = ACC_W'(in_data);

  sdec_stage #(.W(ACC_W), .M(M1), .NSEC(L), .KIND(STG_PLAIN)) u_stg1 (
    .clk(clk), .rst(rst), .en(in_valid), .din(x_ext), .dvld(s1_vld), .dout(s1_d)
  );

  sdec_stage #(.W(ACC_W), .M(M2), .NSEC(K), .KIND(STG_SHARP)) u_stg2 (
    .clk(clk), .rst(rst), .en(s1_vld), .din(s1_d), .dvld(s2_vld), .dout(s2_d)
  );

  sdec_stage #(.W(ACC_W), .M(M3), .NSEC(K), .KIND(STG_SHARP)) u_stg3 (
    .clk(clk), .rst(rst), .en(s2_vld), .din(s2_d), .dvld(s3_vld), .dout(s3_d)
  );

  sdec_round_sat #(.W(ACC_W), .SH(SH), .WO(W_OUT)) u_out (
    .clk(clk), .rst(rst), .en(s3_vld), .din(s3_d), .dvld(out_valid), .dout(out_data)
  );

endmodule

// File: rtl/sharp_comb_decim_chk.sv
module sharp_comb_decim_chk #(
  parameter int W_OUT = 16,
  parameter int TOT   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [W_OUT-1:0] out_data,
  input logic                    s1_vld,
  input logic                    s2_vld,
  input logic                    s3_vld
);

  localparam int CW = (TOT > 1) ? $clog2(TOT) : 1;

  logic [CW-1:0] cnt;
  logic          fire;
  logic          rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)           cnt <= '0;
    else if (in_valid) cnt <= (cnt == CW'(TOT - 1)) ? '0 : cnt + 1'b1;
  end

  assign fire = in_valid && !rst && (cnt == CW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R8: assert (!out_valid && out_data == '0)
        else $error("R8 output not clear during reset");
    end
  end

  assert_cadence_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(fire, 4));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  assert_s2_fed_R3: assert property (@(posedge clk) disable iff (rst)
    s2_vld |-> $past(s1_vld));

  assert_s3_fed_R4: assert property (@(posedge clk) disable iff (rst)
    s3_vld |-> $past(s2_vld));

endmodule

bind sharp_comb_decim sharp_comb_decim_chk #(
  .W_OUT(W_OUT),
  .TOT  (M1 * M2 * M3)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_data (out_data),
  .s1_vld   (s1_vld),
  .s2_vld   (s2_vld),
  .s3_vld   (s3_vld)
);

// File: tb/sharp_comb_decim_tb.sv
module sharp_comb_decim_tb;

  localparam int W_IN  = 16;
  localparam int W_OUT = 16;
  localparam int M1    = 2;
  localparam int M2    = 2;
  localparam int M3    = 4;
  localparam int L     = 4;
  localparam int K     = 2;
  localparam int TOT   = M1 * M2 * M3;
  localparam int NMAX  = 4096;
  localparam int SH    = L * $clog2(M1) + 3 * K * ($clog2(M2) + $clog2(M3));
  localparam longint OMAX = (64'sd1 <<< (W_OUT - 1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (W_OUT - 1));

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic signed [W_IN-1:0]  in_data = '0;
  logic                    out_valid;
  logic signed [W_OUT-1:0] out_data;

  sharp_comb_decim #(
    .W_IN(W_IN), .W_OUT(W_OUT), .M1(M1), .M2(M2), .M3(M3), .L(L), .K(K)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int     n_cmp = 0;
  int     n_bad = 0;
  int     cyc = 0;
  int     acc_cnt = 0;
  bit     done = 1'b0;
  string  cur_tag = "R3";
  longint last_out = 0;
  int     exp_time [$];
  longint exp_val  [$];

  // model state: per stage, per section, full history of the current segment
  longint hs [3][7][NMAX];
  int     ns [3];
  int     stm [3] = '{M1, M2, M3};
  int     stn [3] = '{L, K, K};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 3; s++) ns[s] = 0;
    acc_cnt = 0;
  endtask

  task automatic model_push(input longint x);
    longint v = x;
    longint y;
    bit     live = 1'b1;
    for (int s = 0; s < 3 && live; s++) begin
      int idx = ns[s];
      int m   = stm[s];
      int nsc = (s == 0) ? stn[s] : 3 * stn[s];
      hs[s][0][idx] = v;
      for (int j = 1; j <= nsc; j++) begin
        longint acc = 0;
        for (int i = 0; i < m; i++)
          if (idx - i >= 0) acc += hs[s][j-1][idx-i];
        hs[s][j][idx] = acc;
      end
      ns[s] = idx + 1;
      if (s == 0) begin
        y = hs[0][nsc][idx];
      end else begin
        int d  = stn[s] * (m - 1) / 2;
        int gs = stn[s] * $clog2(m);
        longint a = (idx - d >= 0) ? hs[s][2*stn[s]][idx-d] : 0;
        y = 3 * (a <<< gs) - 2 * hs[s][nsc][idx];
      end
      if ((idx % m) != m - 1) live = 1'b0;
      else v = y;
    end
    if (live) begin
      longint q = (v + (64'sd1 <<< (SH - 1))) >>> SH;
      if (q > OMAX) q = OMAX;
      if (q < OMIN) q = OMIN;
      exp_val.push_back(q);
    end
  endtask

  task automatic feed(input bit v, input logic signed [W_IN-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) begin
      model_push(longint'(d));
      acc_cnt++;
      if (acc_cnt % TOT == 0) exp_time.push_back(cyc + 4);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) feed(1'b0, W_IN'($urandom));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_data == 0, "R8", "outputs during reset",
        longint'(out_data) + (out_valid ? 1000000 : 0), 0);
    exp_time.delete();
    exp_val.delete();
    model_reset();
    rst = 1'b0;
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_time.size() > 0 && exp_time[0] < cyc) begin
        chk(1'b0, "R1", "missing output pulse", cyc, exp_time[0]);
        void'(exp_time.pop_front());
        if (exp_val.size() > 0) void'(exp_val.pop_front());
      end
      if (out_valid) begin
        if (exp_time.size() == 0) begin
          chk(1'b0, "R1", "unexpected output pulse at cycle", cyc, -1);
        end else begin
          chk(exp_time[0] == cyc, "R1", "output pulse cycle", cyc, exp_time[0]);
          void'(exp_time.pop_front());
          if (exp_val.size() > 0)
            chk(longint'(out_data) == exp_val[0], cur_tag, "output value",
                longint'(out_data), exp_val[0]);
          if (exp_val.size() > 0) void'(exp_val.pop_front());
        end
        last_out = longint'(out_data);
      end
    end
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    do_reset();                          // R8 reset state

    // impulse through all three stages: R3, R4
    cur_tag = "R3";
    feed(1'b1, 16'sd32767);
    for (int i = 0; i < 95; i++) feed(1'b1, 16'sd0);
    idle(8);

    // unity DC gain: R5
    do_reset();
    cur_tag = "R5";
    for (int i = 0; i < 256; i++) feed(1'b1, 16'sd1000);
    idle(8);
    chk(last_out == 1000, "R5", "settled DC +1000", last_out, 1000);
    do_reset();
    for (int i = 0; i < 256; i++) feed(1'b1, -16'sd32768);
    idle(8);
    chk(last_out == -32768, "R5", "settled DC min", last_out, -32768);

    // strobe gaps with junk data: R2
    do_reset();
    cur_tag = "R2";
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 2) feed(1'b1, W_IN'($urandom));
      else              feed(1'b0, W_IN'($urandom));
    end
    idle(8);

    // full-scale steps that overshoot: R7
    do_reset();
    cur_tag = "R7";
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 96; i++) feed(1'b1, -16'sd32768);
      for (int i = 0; i < 96; i++) feed(1'b1, 16'sd32767);
    end
    for (int i = 0; i < 256; i++) feed(1'b1, ((i / 3) % 2) ? 16'sd32767 : -16'sd32768);
    idle(8);

    // reset restarts the phase: R8
    do_reset();
    cur_tag = "R8";
    for (int i = 0; i < 7; i++) feed(1'b1, 16'sd500);
    idle(2);
    do_reset();
    for (int i = 0; i < TOT; i++) feed(1'b1, 16'sd500);
    idle(8);
    chk(exp_time.size() == 0, "R8", "pending pulses after restart", exp_time.size(), 0);

    // small values exercise the rounding: R6
    do_reset();
    cur_tag = "R6";
    for (int i = 0; i < 640; i++) feed(1'b1, W_IN'(int'($urandom % 7) - 3));
    idle(8);

    // wide random stream, mostly gapless: R4
    do_reset();
    cur_tag = "R4";
    for (int i = 0; i < 1600; i++) begin
      if ($urandom % 8 != 0) feed(1'b1, W_IN'($urandom));
      else                   feed(1'b0, W_IN'($urandom));
    end
    idle(8);
    chk(exp_time.size() == 0, "R1", "pulses left unmatched", exp_time.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule